// File: doc/BRIEF.md
# YCbCr 4:2:2 Input Formatter

This block sits at the pixel input of a video encoder. It takes 4:2:2 YCbCr samples from either a 16-bit bus or an 8-bit bus. On the 16-bit bus, luma and multiplexed chroma arrive side by side. On the 8-bit bus, all components are interleaved into one byte stream. The block emits one luma sample per pixel together with the chroma pair that is co-sited with it. Each emitted pixel is flagged by a valid strobe, so a later 4:4:4 interpolation stage can consume it directly.

The block runs on the double-rate pixel clock. A half-rate phase input marks which edges carry 16-bit data. A blanking signal decides when pixels are taken. That signal either comes from outside, or the block builds it from an active-window input. When the block builds it, the first pixel is taken on one of two edges. In aligned timing it is taken on the edge right after blanking drops. In early timing the source has to be one pixel period behind, so capture starts two fast-clock edges later. Luma below the black floor is raised to the floor. Luma above white, and all chroma, pass through untouched.

Top module: `ycc422_formatter`

## Requirements
- R1: With `wide_mode`=0, one byte is taken from `pix_bus[15:8]` on every `clk2` rising edge while capture is enabled, in the order Cb, Y0, Cr, Y1, and that order repeats.
- R2: With `wide_mode`=1, luma is taken from `pix_bus[15:8]` and chroma from `pix_bus[7:0]` (Cb on the first capture, then Cr), only on `clk2` edges where `half_clk` is 0. Bus values at edges where `half_clk` is 1 have no effect.
- R3: An emitted luma value below 16 is output as 16. Values of 16 and above, including those above 235, are output unchanged.
- R4: Cb and Cr are output exactly as captured, with no range limiting.
- R5: Two pixels come out of each Cb/Y0/Cr/Y1 group. Pixel 0 (Y0 with that Cb and Cr) has `pix_vld` high for the cycle after the edge that takes Cr. Pixel 1 (Y1 with the same Cb and Cr) has `pix_vld` high in the cycle after that. `pix_vld` is low otherwise.
- R6: With `blank_is_out`=0, `blank_in` is sampled on the same edge as the pixel data, and no data is taken on an edge where it is 1.
- R7: Any edge on which capture is disabled by blanking returns the chroma phase to Cb, so the next captured sample is treated as Cb.
- R8: `blank_out` is the registered inverse of `act_win`. It updates on every edge when `wide_mode`=0, and only on edges with `half_clk`=1 when `wide_mode`=1.
- R9: With `blank_is_out`=1 and `blank_aligned`=1, the first byte is taken on the first edge after the one that drove `blank_out` low.
- R10: With `blank_is_out`=1 and `blank_aligned`=0, the first byte is taken two `clk2` edges later than in R9.
- R11: During and right after reset, `pix_vld`=0, `blank_out`=1 and `y_o`, `cb_o`, `cr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_clk | input | 1 | Half-rate phase; 16-bit data is taken when low |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit interleaved bus |
| blank_is_out | input | 1 | 1 = blanking generated from `act_win`, 0 = taken from `blank_in` |
| blank_aligned | input | 1 | Generated-blank timing: 1 = aligned, 0 = early |
| blank_in | input | 1 | External blanking, active high |
| act_win | input | 1 | Active-picture window from the timing generator |
| pix_bus | input | 2*DW | Pixel bus; upper byte luma or interleaved byte, lower byte chroma |
| blank_out | output | 1 | Generated blanking, active high |
| y_o | output | DW | Luma of the emitted pixel, floor-limited |
| cb_o | output | DW | Cb co-sited with the emitted pixel |
| cr_o | output | DW | Cr co-sited with the emitted pixel |
| pix_vld | output | 1 | Emitted-pixel strobe |

## Verification
The hardest case to reach is early generated-blank timing. Here `blank_out` has already fallen, yet two more bus values must still be discarded before the Cb byte counts. A misplaced delay tap shows up only as a one-byte shift in which component lands where. The bench holds `act_win` low long enough to flush the delay history, then raises it and feeds distinct marker bytes on every edge. That way each possible misalignment produces a different wrong Y, Cb or Cr. A mid-line blanking pulse after a half-finished group is used the same way to show that the chroma phase restarts on Cb.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } byte_phase_e;
endpackage

// File: rtl/ycc_blank_ctl.sv
module ycc_blank_ctl #(
  parameter int EARLY_LAG = 2
) (
  input  logic clk2,
  input  logic rst_n,
  input  logic half_clk,
  input  logic wide_mode,
  input  logic blank_is_out,
  input  logic blank_aligned,
  input  logic blank_in,
  input  logic act_win,
  output logic blank_out,
  output logic gate,
  output logic cap_en
);
  localparam int HW = (EARLY_LAG < 2) ? 2 : EARLY_LAG;

  logic          blank_q;
  logic [HW-1:0] blank_hist;
  logic          upd_edge;

  // 16-bit mode moves generated controls only on high-phase edges
  assign upd_edge = !wide_mode || half_clk;

  always_ff @(posedge clk2) begin
    if (!rst_n) begin
      blank_q    <= 1'b1;
      blank_hist <= '1;
    end else begin
      if (upd_edge) blank_q <= !act_win;
      blank_hist <= {blank_hist[HW-2:0], blank_q};
    end
  end

  assign blank_out = blank_q;

  always_comb begin
    if (!blank_is_out)      gate = !blank_in;
    else if (blank_aligned) gate = !blank_q;
    else                    gate = !blank_hist[HW-1];
  end

  assign cap_en = gate && (!wide_mode || !half_clk);
endmodule

// File: rtl/ycc_capture.sv
module ycc_capture
  import ycc_fmt_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LUMA_FLOOR = 16
) (
  input  logic            clk2,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            gate,
  input  logic            cap_en,
  input  logic [2*DW-1:0] pix_bus,
  output logic [DW-1:0]   y_o,
  output logic [DW-1:0]   cb_o,
  output logic [DW-1:0]   cr_o,
  output logic            pix_vld,
  output byte_phase_e     phase,
  output logic            emit_first,
  output logic            emit_second
);
  localparam logic [DW-1:0] FLOOR_V = DW'(LUMA_FLOOR);

  function automatic logic [DW-1:0] floor_luma(input logic [DW-1:0] v);
    return (v < FLOOR_V) ? FLOOR_V : v;
  endfunction

  logic [DW-1:0] hi_b, lo_b;
  logic [DW-1:0] cb_hold, y0_hold, y1_hold;
  logic          pend2;

  assign hi_b = pix_bus[2*DW-1:DW];
  assign lo_b = pix_bus[DW-1:0];

  assign emit_first  = cap_en && (phase == PH_CR);
  assign emit_second = wide_mode ? pend2 : (cap_en && (phase == PH_Y1));

  always_ff @(posedge clk2) begin
    if (!rst_n) begin
      phase   <= PH_CB;
      cb_hold <= '0;
      y0_hold <= '0;
      y1_hold <= '0;
      pend2   <= 1'b0;
      y_o     <= '0;
      cb_o    <= '0;
      cr_o    <= '0;
      pix_vld <= 1'b0;
    end else begin
      pix_vld <= 1'b0;
      pend2   <= 1'b0;
      if (pend2) begin
        y_o     <= floor_luma(y1_hold);
        pix_vld <= 1'b1;
      end
      if (!gate) begin
        phase <= PH_CB;
      end else if (cap_en) begin
        if (wide_mode) begin
          if (phase == PH_CB) begin
            cb_hold <= lo_b;
            y0_hold <= hi_b;
            phase   <= PH_CR;
          end else begin
            cb_o    <= cb_hold;
            cr_o    <= lo_b;
            y_o     <= floor_luma(y0_hold);
            y1_hold <= hi_b;
            pix_vld <= 1'b1;
            pend2   <= 1'b1;
            phase   <= PH_CB;
          end
        end else begin
          unique case (phase)
            PH_CB: begin
              cb_hold <= hi_b;
              phase   <= PH_Y0;
            end
            PH_Y0: begin
              y0_hold <= hi_b;
              phase   <= PH_CR;
            end
            PH_CR: begin
              cb_o    <= cb_hold;
              cr_o    <= hi_b;
              y_o     <= floor_luma(y0_hold);
              pix_vld <= 1'b1;
              phase   <= PH_Y1;
            end
            PH_Y1: begin
              y_o     <= floor_luma(hi_b);
              pix_vld <= 1'b1;
              phase   <= PH_CB;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ycc422_formatter.sv
module ycc422_formatter
  import ycc_fmt_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LUMA_FLOOR = 16,
  parameter int EARLY_LAG  = 2
) (
  input  logic            clk2,
  input  logic            rst_n,
  input  logic            half_clk,
  input  logic            wide_mode,
  input  logic            blank_is_out,
  input  logic            blank_aligned,
  input  logic            blank_in,
  input  logic            act_win,
  input  logic [2*DW-1:0] pix_bus,
  output logic            blank_out,
  output logic [DW-1:0]   y_o,
  output logic [DW-1:0]   cb_o,
  output logic [DW-1:0]   cr_o,
  output logic            pix_vld
);
  // named internal events, observed by the bound checker
  logic        gate;
  logic        cap_en;
  byte_phase_e phase;
  logic        emit_first;
  logic        emit_second;

  ycc_blank_ctl #(.EARLY_LAG(EARLY_LAG)) u_blank (
    .clk2          (clk2),
    .rst_n         (rst_n),
    .half_clk      (half_clk),
    .wide_mode     (wide_mode),
    .blank_is_out  (blank_is_out),
    .blank_aligned (blank_aligned),
    .blank_in      (blank_in),
    .act_win       (act_win),
    .blank_out     (blank_out),
    .gate          (gate),
    .cap_en        (cap_en)
  );

  ycc_capture #(.DW(DW), .LUMA_FLOOR(LUMA_FLOOR)) u_cap (
    .clk2        (clk2),
    .rst_n       (rst_n),
    .wide_mode   (wide_mode),
    .gate        (gate),
    .cap_en      (cap_en),
    .pix_bus     (pix_bus),
    .y_o         (y_o),
    .cb_o        (cb_o),
    .cr_o        (cr_o),
    .pix_vld     (pix_vld),
    .phase       (phase),
    .emit_first  (emit_first),
    .emit_second (emit_second)
  );
endmodule

// File: rtl/ycc_fmt_chk.sv
module ycc_fmt_chk
  import ycc_fmt_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LUMA_FLOOR = 16
) (
  input logic          clk2,
  input logic          rst_n,
  input logic          half_clk,
  input logic          wide_mode,
  input logic          blank_is_out,
  input logic          blank_in,
  input logic          blank_out,
  input logic [DW-1:0] y_o,
  input logic [DW-1:0] cb_o,
  input logic [DW-1:0] cr_o,
  input logic          pix_vld,
  input logic          gate,
  input logic          cap_en,
  input byte_phase_e   phase,
  input logic          emit_first,
  input logic          emit_second
);
  // R1: in byte mode the Cr capture yields a pixel on the next cycle
  a_r1_cr_emits: assert property (@(posedge clk2) disable iff (!rst_n)
    (!wide_mode && emit_first) |=> pix_vld);

  // R2: no capture on high-phase edges in 16-bit mode
  a_r2_low_phase_only: assert property (@(posedge clk2) disable iff (!rst_n)
    (wide_mode && half_clk) |-> !cap_en);

  // R3: emitted luma never below the black floor
  a_r3_luma_floor: assert property (@(posedge clk2) disable iff (!rst_n)
    pix_vld |-> (y_o >= DW'(LUMA_FLOOR)));

  // R5: second pixel of a pair reuses the chroma of the first
  a_r5_chroma_shared: assert property (@(posedge clk2) disable iff (!rst_n)
    (pix_vld && $past(pix_vld)) |-> ($stable(cb_o) && $stable(cr_o)));

  // R5: never more than two emitted pixels in a row
  a_r5_pair_only: assert property (@(posedge clk2) disable iff (!rst_n)
    (pix_vld && $past(pix_vld)) |=> !pix_vld);

  // R5: a second-pixel event is followed by a strobe
  a_r5_second_strobe: assert property (@(posedge clk2) disable iff (!rst_n)
    emit_second |=> pix_vld);

  // R6: external blank high blocks capture
  a_r6_blank_blocks: assert property (@(posedge clk2) disable iff (!rst_n)
    (!blank_is_out && blank_in) |-> !cap_en);

  // R7: blanking returns the phase to Cb
  a_r7_phase_restart: assert property (@(posedge clk2) disable iff (!rst_n)
    !gate |=> (phase == PH_CB));

  // R8: generated blank holds across low-phase edges in 16-bit mode
  a_r8_blank_hold: assert property (@(posedge clk2) disable iff (!rst_n)
    (wide_mode && !half_clk) |=> $stable(blank_out));
endmodule

bind ycc422_formatter ycc_fmt_chk #(.DW(DW), .LUMA_FLOOR(LUMA_FLOOR)) u_chk (
  .clk2         (clk2),
  .rst_n        (rst_n),
  .half_clk     (half_clk),
  .wide_mode    (wide_mode),
  .blank_is_out (blank_is_out),
  .blank_in     (blank_in),
  .blank_out    (blank_out),
  .y_o          (y_o),
  .cb_o         (cb_o),
  .cr_o         (cr_o),
  .pix_vld      (pix_vld),
  .gate         (gate),
  .cap_en       (cap_en),
  .phase        (phase),
  .emit_first   (emit_first),
  .emit_second  (emit_second)
);

// File: tb/ycc422_formatter_test.sv
module ycc422_formatter_test;
  logic        clk2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_clk = 1'b0;
  logic        wide_mode = 1'b0;
  logic        blank_is_out = 1'b0;
  logic        blank_aligned = 1'b1;
  logic        blank_in = 1'b1;
  logic        act_win = 1'b0;
  logic [15:0] pix_bus = '0;
  logic        blank_out;
  logic [7:0]  y_o, cb_o, cr_o;
  logic        pix_vld;

  int checks = 0;
  int errors = 0;

  always #5 clk2 = ~clk2;

  ycc422_formatter uut (
    .clk2(clk2), .rst_n(rst_n), .half_clk(half_clk), .wide_mode(wide_mode),
    .blank_is_out(blank_is_out), .blank_aligned(blank_aligned),
    .blank_in(blank_in), .act_win(act_win), .pix_bus(pix_bus),
    .blank_out(blank_out), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o),
    .pix_vld(pix_vld)
  );

  // fields: cb, y0, cr, y1, expected y0, expected y1
  localparam logic [47:0] VEC [5] = '{
    {8'h80, 8'h00, 8'h80, 8'h0F, 8'h10, 8'h10},
    {8'h10, 8'h10, 8'hF0, 8'h11, 8'h10, 8'h11},
    {8'h00, 8'hEB, 8'hFF, 8'hEC, 8'hEB, 8'hEC},
    {8'hF5, 8'hFF, 8'h05, 8'h0F, 8'hFF, 8'h10},
    {8'h01, 8'h0A, 8'hFE, 8'h40, 8'h10, 8'h40}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive inputs, take one edge, settle away from it
  task automatic tick(input logic hc, input logic [15:0] bus, input logic blk);
    half_clk = hc;
    pix_bus  = bus;
    blank_in = blk;
    act_win  = act_win;
    @(posedge clk2);
    #1;
  endtask

  task automatic win_tick(input logic hc, input logic [15:0] bus, input logic aw);
    act_win = aw;
    tick(hc, bus, 1'b1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk2);
    #1;
    chk("R11 vld", pix_vld, 0);
    chk("R11 blank_out", blank_out, 1);
    chk("R11 y", y_o, 0);
    chk("R11 cb", cb_o, 0);
    rst_n = 1'b1;
    tick(0, 16'h0000, 1);
    chk("R11 vld after release", pix_vld, 0);

    // table walk, byte mode, external blank (R1 R3 R4 R5 R6)
    wide_mode = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick(0, 16'hEE00, 1);
      chk("R6 blank high no strobe", pix_vld, 0);
      tick(0, {VEC[i][47:40], 8'h00}, 0);
      tick(0, {VEC[i][39:32], 8'h00}, 0);
      chk("R5 no strobe before Cr", pix_vld, 0);
      tick(0, {VEC[i][31:24], 8'h00}, 0);
      chk("R5 pix0 vld", pix_vld, 1);
      chk("R3 R1 pix0 y", y_o, VEC[i][15:8]);
      chk("R4 R1 pix0 cb", cb_o, VEC[i][47:40]);
      chk("R4 R1 pix0 cr", cr_o, VEC[i][31:24]);
      tick(0, {VEC[i][23:16], 8'h00}, 0);
      chk("R5 pix1 vld", pix_vld, 1);
      chk("R3 pix1 y", y_o, VEC[i][7:0]);
      chk("R5 pix1 cb kept", cb_o, VEC[i][47:40]);
      chk("R5 pix1 cr kept", cr_o, VEC[i][31:24]);
      tick(0, 16'h0000, 1);
      chk("R5 strobe drops", pix_vld, 0);
    end

    // table walk, 16-bit mode (R2)
    wide_mode = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick(0, 16'h0000, 1);
      tick(1, 16'hAAAA, 0);
      tick(0, {VEC[i][39:32], VEC[i][47:40]}, 0);
      tick(1, 16'h5555, 0);
      tick(0, {VEC[i][23:16], VEC[i][31:24]}, 0);
      chk("R2 pix0 vld", pix_vld, 1);
      chk("R2 R3 pix0 y", y_o, VEC[i][15:8]);
      chk("R2 pix0 cb", cb_o, VEC[i][47:40]);
      chk("R2 pix0 cr", cr_o, VEC[i][31:24]);
      tick(1, 16'h3333, 0);
      chk("R2 pix1 vld", pix_vld, 1);
      chk("R2 R3 pix1 y", y_o, VEC[i][7:0]);
      chk("R2 pix1 cr kept", cr_o, VEC[i][31:24]);
    end

    // R7 mid-line resync restarts on Cb
    wide_mode = 1'b0;
    tick(0, 16'h0000, 1);
    tick(0, 16'h1100, 0);
    tick(0, 16'h5000, 0);
    tick(0, 16'h0000, 1);
    chk("R7 no strobe on blank", pix_vld, 0);
    tick(0, 16'h2200, 0);
    tick(0, 16'h6000, 0);
    tick(0, 16'h3300, 0);
    chk("R7 vld", pix_vld, 1);
    chk("R7 y", y_o, 8'h60);
    chk("R7 cb restart", cb_o, 8'h22);
    chk("R7 cr", cr_o, 8'h33);

    // R9 aligned generated blank, byte mode
    blank_is_out = 1'b1;
    blank_aligned = 1'b1;
    repeat (4) win_tick(0, 16'h0000, 0);
    chk("R8 blank_out high", blank_out, 1);
    win_tick(0, 16'h9900, 1);
    chk("R8 blank_out falls", blank_out, 0);
    win_tick(0, 16'h4000, 1);
    win_tick(0, 16'h5000, 1);
    win_tick(0, 16'h6000, 1);
    chk("R9 vld", pix_vld, 1);
    chk("R9 y", y_o, 8'h50);
    chk("R9 cb", cb_o, 8'h40);
    chk("R9 cr", cr_o, 8'h60);
    win_tick(0, 16'h7000, 1);
    chk("R9 pix1 y", y_o, 8'h70);

    // R10 early generated blank
    blank_aligned = 1'b0;
    repeat (4) win_tick(0, 16'h0000, 0);
    win_tick(0, 16'h9900, 1);
    chk("R10 blank_out falls", blank_out, 0);
    win_tick(0, 16'h9800, 1);
    win_tick(0, 16'h9700, 1);
    win_tick(0, 16'h4100, 1);
    win_tick(0, 16'h5100, 1);
    chk("R10 no strobe yet", pix_vld, 0);
    win_tick(0, 16'h6100, 1);
    chk("R10 vld", pix_vld, 1);
    chk("R10 y", y_o, 8'h51);
    chk("R10 cb", cb_o, 8'h41);
    chk("R10 cr", cr_o, 8'h61);
    win_tick(0, 16'h7100, 1);
    chk("R10 pix1 y", y_o, 8'h71);

    // R8 16-bit: generated blank moves only on high-phase edges
    wide_mode = 1'b1;
    blank_aligned = 1'b1;
    repeat (4) win_tick(1, 16'h0000, 0);
    win_tick(0, 16'h0000, 1);
    chk("R8 held on low phase", blank_out, 1);
    win_tick(1, 16'h0000, 1);
    chk("R8 updates on high phase", blank_out, 0);
    win_tick(0, 16'h5542, 1);
    win_tick(1, 16'hFFFF, 1);
    win_tick(0, 16'h6643, 1);
    chk("R9 R2 vld", pix_vld, 1);
    chk("R9 R2 y", y_o, 8'h55);
    chk("R9 R2 cb", cb_o, 8'h42);
    chk("R9 R2 cr", cr_o, 8'h43);
    win_tick(1, 16'h0000, 0);
    chk("R2 pix1 y", y_o, 8'h66);
    chk("R8 rises on high phase", blank_out, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule